// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

A single-ported synchronous SRAM whose word is 36 bits wide: four byte lanes, each with its own parity bit. Every control input is taken on the rising clock edge. An access opens when all three chip selects are true and one of two start strobes is low. The processor-side strobe always opens the access as a read. The controller-side strobe can write in its own cycle.

Once an access is open, further words of the burst are reached with an advance input. A two-bit counter steps through a four-word block in either linear or interleaved order and wraps inside that block. Writes go to all four lanes under a global write override, or to selected lanes under a byte-write enable. The read path is flow-through: the word at the registered address shows on the output in the cycle after the edge that set the address. An asynchronous output enable gates the drive flag. The drive flag also drops as soon as any write qualifier is seen. A snooze input freezes the block.

Top module: `bsram_top`

## Requirements
- R1: After reset, no access is open and `rdata_oe_o` is 0. Whenever `rdata_oe_o` is 0, `rdata_o` is all zeros.
- R2: An access starts only at an edge where `ce1_ni`=0, `ce2_i`=1, `ce3_ni`=0 and a strobe is low. A controller strobe with the selects not all true closes the access. So does a processor strobe with `ce1_ni`=0 and another select false. A processor strobe while `ce1_ni`=1 is ignored.
- R3: At a read start, the block latches `addr_i`. In the next cycle, if `out_en_ni`=0, `rdata_oe_o`=1 and `rdata_o` carries the stored word.
- R4: At a processor-strobe start edge the write inputs have no effect. A write at the next edge with `adv_ni`=1 stores to the start address.
- R5: A controller-strobe start with any write qualifier active stores `wdata_i` to `addr_i` at that edge. With no write qualifier active, it is a read start.
- R6: Burst addresses keep the upper address bits and change only the low two. With `burst_ilv_i`=0 the low bits are base+count mod 4. With `burst_ilv_i`=1 they are base XOR count.
- R7: With no strobe, an open access and no write: `adv_ni`=0 steps the counter and reads the new word, and `adv_ni`=1 holds the address and output. A write with `adv_ni`=0 stores to the stepped address.
- R8: `glob_wr_ni`=0 writes all four lanes, whatever `byte_wr_ni` and `lane_sel_ni` are.
- R9: With `glob_wr_ni`=1 and `byte_wr_ni`=0, each `lane_sel_ni[k]`=0 writes `wdata_i[8k+7:8k]` and parity bit `wdata_i[32+k]`. Other lanes keep their contents.
- R10: With `glob_wr_ni`=1 and `byte_wr_ni`=1, no lane is written, whatever `lane_sel_ni` is.
- R11: `out_en_ni`=1 forces `rdata_oe_o`=0 in the same cycle.
- R12: Any active write qualifier forces `rdata_oe_o`=0 in the same cycle, whatever `out_en_ni` is.
- R13: While `snooze_i`=1, all other inputs are ignored, the state and array contents are held, and `rdata_oe_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address, AW = clog2(DEPTH) |
| ce1_ni | input | 1 | Chip select, active low; also gates the processor strobe |
| ce2_i | input | 1 | Chip select, active high |
| ce3_ni | input | 1 | Chip select, active low |
| proc_strb_ni | input | 1 | Processor-side start strobe, active low |
| ctrl_strb_ni | input | 1 | Controller-side start strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| glob_wr_ni | input | 1 | Global write of all lanes, active low |
| byte_wr_ni | input | 1 | Byte-write enable, active low |
| lane_sel_ni | input | 4 | Per-lane write select, active low |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| snooze_i | input | 1 | Freeze, active high |
| burst_ilv_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| wdata_i | input | 36 | Write word: data in bits 31:0, parity of lane k in bit 32+k |
| rdata_o | output | 36 | Read word, zero when not driven |
| rdata_oe_o | output | 1 | Output drive flag; 0 means tristate |

## Verification
The array is first filled with a distinct word per address using controller-strobe global writes. After that, every read exposes the address it came from. Bursts from a base with low bits 01 are run in both orders, and the step sequences 9,10,11,8 and 9,8,11,10 separate addition from XOR and show wrap inside the block. A processor start with global write held low, followed by a two-lane byte write, shows that the first-cycle write qualifiers were ignored and which lanes and parity bits were changed. Select mixes, the snooze freeze and writes under a low output enable separate ignored strobes from deselects and held state from lost state.

// File: rtl/bsram_pkg.sv
`timescale 1ns/1ps
package bsram_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * (BYTE_W + 1);
  localparam int CNT_W  = 2;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_START_P,
    OP_START_C,
    OP_START_CW,
    OP_DESEL,
    OP_CONT_WR,
    OP_CONT_RD
  } op_e;
endpackage

// File: rtl/bsram_lane_dec.sv
`timescale 1ns/1ps
module bsram_lane_dec #(
  parameter int LANES = 4
) (
  input  logic             glob_wr_ni,
  input  logic             byte_wr_ni,
  input  logic [LANES-1:0] lane_sel_ni,
  output logic [LANES-1:0] mask_o,
  output logic             any_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign mask_o[k] = ~glob_wr_ni | (~byte_wr_ni & ~lane_sel_ni[k]);
  end
  assign any_o = |mask_o;
endmodule

// File: rtl/bsram_burst_gen.sv
`timescale 1ns/1ps
module bsram_burst_gen #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] base_lo_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ilv_i,
  output logic [CNT_W-1:0] cur_lo_o,
  output logic [CNT_W-1:0] nxt_lo_o
);
  logic [CNT_W-1:0] cnt_nxt;
  assign cnt_nxt  = cnt_i + CNT_W'(1);
  // linear order adds the count, interleaved order XORs it into the base
  assign cur_lo_o = ilv_i ? (base_lo_i ^ cnt_i)   : (base_lo_i + cnt_i);
  assign nxt_lo_o = ilv_i ? (base_lo_i ^ cnt_nxt) : (base_lo_i + cnt_nxt);
endmodule

// File: rtl/bsram_array.sv
`timescale 1ns/1ps
module bsram_array #(
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int WORD_W = LANES * (BYTE_W + 1)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [LANES-1:0]  mask_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [BYTE_W:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && mask_i[k])
        mem_q[waddr_i] <= {wdata_i[LANES*BYTE_W+k], wdata_i[k*BYTE_W +: BYTE_W]};
    end

    assign rdata_o[k*BYTE_W +: BYTE_W] = mem_q[raddr_i][BYTE_W-1:0];
    assign rdata_o[LANES*BYTE_W+k]     = mem_q[raddr_i][BYTE_W];
  end
endmodule

// File: rtl/bsram_top.sv
`timescale 1ns/1ps
module bsram_top
  import bsram_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              proc_strb_ni,
  input  logic              ctrl_strb_ni,
  input  logic              adv_ni,
  input  logic              glob_wr_ni,
  input  logic              byte_wr_ni,
  input  logic [LANES-1:0]  lane_sel_ni,
  input  logic              out_en_ni,
  input  logic              snooze_i,
  input  logic              burst_ilv_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rdata_oe_o
);
  logic             sel_q, rd_q;
  logic [AW-1:0]    base_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cur_lo, nxt_lo;
  logic [AW-1:0]    addr_cur, addr_nxt, waddr;
  logic [LANES-1:0] wr_mask;
  logic             wr_any, ce_ok, p_valid, mem_we;
  logic [WORD_W-1:0] arr_rd;
  op_e              op;

  bsram_lane_dec #(.LANES(LANES)) u_dec (
    .glob_wr_ni (glob_wr_ni),
    .byte_wr_ni (byte_wr_ni),
    .lane_sel_ni(lane_sel_ni),
    .mask_o     (wr_mask),
    .any_o      (wr_any)
  );

  bsram_burst_gen #(.CNT_W(CNT_W)) u_burst (
    .base_lo_i(base_q[CNT_W-1:0]),
    .cnt_i    (cnt_q),
    .ilv_i    (burst_ilv_i),
    .cur_lo_o (cur_lo),
    .nxt_lo_o (nxt_lo)
  );

  assign addr_cur = {base_q[AW-1:CNT_W], cur_lo};
  assign addr_nxt = {base_q[AW-1:CNT_W], nxt_lo};

  assign ce_ok   = ~ce1_ni & ce2_i & ~ce3_ni;
  assign p_valid = ~proc_strb_ni & ~ce1_ni;  // processor strobe is ignored while ce1 is high

  always_comb begin
    op = OP_NONE;
    if (!snooze_i) begin
      if (p_valid && ce_ok)       op = OP_START_P;
      else if (!ctrl_strb_ni)     op = ce_ok ? (wr_any ? OP_START_CW : OP_START_C) : OP_DESEL;
      else if (p_valid)           op = OP_DESEL;
      else if (sel_q) begin
        if (wr_any)               op = OP_CONT_WR;
        else if (!adv_ni)         op = OP_CONT_RD;
      end
    end
  end

  assign mem_we = (op == OP_START_CW) || (op == OP_CONT_WR);
  assign waddr  = (op == OP_START_CW) ? addr_i : (adv_ni ? addr_cur : addr_nxt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      rd_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      unique case (op)
        OP_START_P, OP_START_C, OP_START_CW: begin
          base_q <= addr_i;
          cnt_q  <= '0;
          sel_q  <= 1'b1;
          rd_q   <= (op != OP_START_CW);
        end
        OP_DESEL: begin
          sel_q <= 1'b0;
          rd_q  <= 1'b0;
        end
        OP_CONT_WR: begin
          if (!adv_ni) cnt_q <= cnt_q + CNT_W'(1);
          rd_q <= 1'b0;
        end
        OP_CONT_RD: begin
          cnt_q <= cnt_q + CNT_W'(1);
          rd_q  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  bsram_array #(.DEPTH(DEPTH), .LANES(LANES), .BYTE_W(BYTE_W)) u_array (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .mask_i (wr_mask),
    .waddr_i(waddr),
    .wdata_i(wdata_i),
    .raddr_i(addr_cur),
    .rdata_o(arr_rd)
  );

  // flow-through read, drive dropped on any write qualifier
  assign rdata_oe_o = rd_q & ~out_en_ni & ~wr_any & ~snooze_i;
  assign rdata_o    = rdata_oe_o ? arr_rd : '0;

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_q |-> !rdata_oe_o); // R1
  AST_START_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_START_P || op == OP_START_C || op == OP_START_CW)
      |=> (addr_cur == $past(addr_i))); // R3
  AST_DESEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_DESEL) |=> !rdata_oe_o); // R2
  AST_PROC_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_START_P) |-> !mem_we); // R4
  AST_BURST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_CONT_RD) |=> (addr_cur[AW-1:CNT_W] == $past(addr_cur[AW-1:CNT_W]))); // R6
  AST_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> !rdata_oe_o); // R12
  AST_SNOOZE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snooze_i |=> ($stable(addr_cur) && $stable(rd_q) && $stable(sel_q))); // R13
endmodule

// File: tb/tb_bsram_top.sv
`timescale 1ns/1ps
module tb_bsram_top;
  localparam int DEPTH = 64;
  localparam int AW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] a;
  logic ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n, snooze, ilv;
  logic [3:0] bw_n;
  logic [35:0] d;
  logic [35:0] q;
  logic q_oe;

  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  bsram_top #(.DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(a), .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n),
    .proc_strb_ni(adsp_n), .ctrl_strb_ni(adsc_n), .adv_ni(adv_n), .glob_wr_ni(gw_n),
    .byte_wr_ni(bwe_n), .lane_sel_ni(bw_n), .out_en_ni(oe_n), .snooze_i(snooze),
    .burst_ilv_i(ilv), .wdata_i(d), .rdata_o(q), .rdata_oe_o(q_oe)
  );

  // reference model
  logic [35:0] m_mem [DEPTH];
  bit m_sel, m_rd;
  int m_base, m_cnt;

  function automatic logic [35:0] pat(int i);
    return {4'(i ^ 10), 8'(i + 17), 8'(i * 2), 8'(~i), 8'(i ^ 90)};
  endfunction

  function automatic int m_addr();
    int lo;
    lo = ilv ? ((m_base & 3) ^ m_cnt) : (((m_base & 3) + m_cnt) & 3);
    return (m_base & ~3) | lo;
  endfunction

  function automatic logic [3:0] lanes_now();
    logic [3:0] m;
    for (int k = 0; k < 4; k++) m[k] = !gw_n || (!bwe_n && !bw_n[k]);
    return m;
  endfunction

  task automatic m_write(int ad, logic [3:0] m);
    for (int k = 0; k < 4; k++)
      if (m[k]) begin
        m_mem[ad][8*k +: 8] = d[8*k +: 8];
        m_mem[ad][32+k]     = d[32+k];
      end
  endtask

  always @(posedge clk) begin
    logic ceok, pv;
    logic [3:0] m;
    if (!rst_n) begin
      m_sel = 0; m_rd = 0; m_base = 0; m_cnt = 0;
    end else if (!snooze) begin
      ceok = !ce1_n && ce2 && !ce3_n;
      pv = !adsp_n && !ce1_n;
      m = lanes_now();
      if (pv && ceok) begin
        m_base = a; m_cnt = 0; m_sel = 1; m_rd = 1;
      end else if (!adsc_n) begin
        if (ceok) begin
          m_base = a; m_cnt = 0; m_sel = 1;
          if (m != 0) begin m_write(a, m); m_rd = 0; end else m_rd = 1;
        end else begin m_sel = 0; m_rd = 0; end
      end else if (pv) begin
        m_sel = 0; m_rd = 0;
      end else if (m_sel) begin
        if (m != 0) begin
          if (!adv_n) m_cnt = (m_cnt + 1) & 3;
          m_write(m_addr(), m); m_rd = 0;
        end else if (!adv_n) begin
          m_cnt = (m_cnt + 1) & 3; m_rd = 1;
        end
      end
    end
  end

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against model, then take one edge; called at negedge
  task automatic cyc(string req);
    logic eoe;
    #2;
    eoe = m_rd && !oe_n && (lanes_now() == 0) && !snooze;
    chk(req, {35'd0, q_oe}, {35'd0, eoe});
    chk(req, q, eoe ? m_mem[m_addr()] : 36'd0);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 4'hF;
    ce1_n = 0; ce2 = 1; ce3_n = 0; snooze = 0; oe_n = 0; d = '0; a = '0;
  endtask

  task automatic rd_start(int ad);
    idle(); adsp_n = 0; a = AW'(ad); cyc("R3"); idle();
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(); ilv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk("R1", {35'd0, q_oe}, 36'd0);
    chk("R1", q, 36'd0);
    @(negedge clk);

    // R5 and R8: fill with controller-strobe global writes
    for (int i = 0; i < DEPTH; i++) begin
      idle(); adsc_n = 0; a = AW'(i); gw_n = 0; d = pat(i); cyc("R5");
    end
    idle(); cyc("R5");

    // R3 flow-through read
    rd_start(5);
    #1 chk("R3", q, pat(5));
    cyc("R3");

    // R6/R7 linear burst from 9: 10, 11, 8, then hold
    ilv = 0; rd_start(9);
    adv_n = 0; #1 chk("R7", q, pat(9)); cyc("R7");
    #1 chk("R6", q, pat(10)); cyc("R6");
    #1 chk("R6", q, pat(11)); cyc("R6");
    #1 chk("R6", q, pat(8));
    adv_n = 1; cyc("R7"); cyc("R7");
    #1 chk("R7", q, pat(8));

    // R6 interleaved burst from 9: 8, 11, 10
    ilv = 1; rd_start(9);
    adv_n = 0; cyc("R6");
    #1 chk("R6", q, pat(8)); cyc("R6");
    #1 chk("R6", q, pat(11)); cyc("R6");
    #1 chk("R6", q, pat(10));
    adv_n = 1;
    // R11 output enable high
    oe_n = 1; #1 chk("R11", {35'd0, q_oe}, 36'd0); cyc("R11");
    oe_n = 0;
    // R12 write qualifier forces tristate (and writes current address)
    gw_n = 0; d = pat(40); #1 chk("R12", {35'd0, q_oe}, 36'd0); cyc("R12");
    idle(); cyc("R12");
    ilv = 0;

    // R4 processor start ignores write inputs, next edge writes lanes 1 and 3
    idle(); adsp_n = 0; a = 20; gw_n = 0; d = '0; cyc("R4");
    idle(); bwe_n = 0; bw_n = 4'b0101; d = '1; cyc("R4");
    rd_start(20);
    #1 chk("R4", q, pat(20) | 36'hA_FF00_FF00); cyc("R4");

    // R9 byte write lane 0 only
    idle(); adsc_n = 0; a = 30; bwe_n = 0; bw_n = 4'b1110; d = '0; cyc("R9");
    rd_start(30);
    #1 chk("R9", q, pat(30) & ~36'h1_0000_00FF); cyc("R9");

    // R10 byte enable off: no write, read start
    idle(); adsc_n = 0; a = 31; bw_n = 4'h0; d = '0; cyc("R10");
    idle(); #1 chk("R10", q, pat(31)); cyc("R10");

    // R8 global write overrides partial lane selects
    idle(); adsc_n = 0; a = 32; gw_n = 0; bwe_n = 0; bw_n = 4'b1110; d = 36'h1_2345_6789; cyc("R8");
    rd_start(32);
    #1 chk("R8", q, 36'h1_2345_6789); cyc("R8");

    // R7 continuation write with advance goes to stepped address
    rd_start(44);
    gw_n = 0; adv_n = 0; d = 36'h5_0A0B_0C0D; cyc("R7");
    rd_start(45);
    #1 chk("R7", q, 36'h5_0A0B_0C0D); cyc("R7");

    // R2 chip-select handling
    rd_start(5);
    adsp_n = 0; ce1_n = 1; a = 9; cyc("R2");
    idle(); #1 chk("R2", q, pat(5)); cyc("R2");
    adsc_n = 0; ce2 = 0; a = 9; cyc("R2");
    idle(); #1 chk("R2", {35'd0, q_oe}, 36'd0);
    adv_n = 0; cyc("R2");
    idle(); #1 chk("R2", {35'd0, q_oe}, 36'd0); cyc("R2");
    rd_start(6);
    adsp_n = 0; ce3_n = 1; a = 9; cyc("R2");
    idle(); #1 chk("R2", {35'd0, q_oe}, 36'd0); cyc("R2");

    // R13 snooze ignores strobes and writes, keeps state
    rd_start(5);
    snooze = 1; adsc_n = 0; a = 7; gw_n = 0; d = '0;
    #1 chk("R13", {35'd0, q_oe}, 36'd0); cyc("R13");
    adsc_n = 1; adv_n = 0; cyc("R13");
    idle(); #1 chk("R13", q, pat(5)); cyc("R13");
    rd_start(7);
    #1 chk("R13", q, pat(7)); cyc("R13");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule